// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block brings a two-wire bus that may have been left hung (a target still holding SDA low in the middle of a byte, or a line stuck low) back to a known idle state before the main bus controller starts work. It drives SCL and SDA only by pulling them low through open-drain enables. It reads both lines back through a two-flop synchronizer.

A one-cycle start pulse launches the sequence. First the block waits a bounded time for a pending transfer to clear, polling at a fixed interval. Next it holds the main controller in soft reset and releases both lines. While either line reads low, it clocks SCL, up to a fixed number of pulses, and stops early as soon as both lines read high. It then forces a start condition and a stop condition, drops the soft reset, and waits once more before it signals completion. If the bus never reached idle, a sticky flag records this, and the start and stop are issued anyway.

All durations are given in microseconds and turned into system clocks by a clocks-per-microsecond parameter.

Top module: `i2c_bus_recovery`

## Requirements
- R1: After reset, both line enables, the soft-reset output, busy, done and the stuck flag are all low.
- R2: A start pulse while idle raises busy in the next cycle. A start pulse while busy is ignored: the running sequence neither restarts nor lengthens, and done fires once.
- R3: The pending input is sampled every POLL_US microseconds after start. Soft reset asserts at the first sample that finds it low, or after POLL_MAX samples, whichever comes first.
- R4: Soft reset is high whenever either line enable is active. It falls only with both enables inactive, after the stop phase.
- R5: If both synchronized lines read high after release, no SCL pulse is issued.
- R6: While either line reads low, each SCL pulse pulls SCL low for exactly PULSE_US and then releases it for PULSE_US. The lines are re-checked after each pulse, and clocking stops as soon as both read high.
- R7: At most PULSE_MAX SCL pulses are issued. If a line is still low after the last one, the stuck flag (held until the next start) is set, and the start and stop phases still follow.
- R8: The start phase pulls SDA low with the SCL enable inactive for exactly HOLD_US. The stop phase then releases SDA for exactly HOLD_US before soft reset falls.
- R9: Done is a single-cycle pulse that comes HOLD_US after soft reset falls. Busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch the recovery sequence (pulse) |
| pending_i | input | 1 | Main controller reports a transfer in progress |
| scl_i | input | 1 | SCL line level as seen at the pad |
| sda_i | input | 1 | SDA line level as seen at the pad |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| ctrl_srst_o | output | 1 | Soft reset to the main controller |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |
| stuck_o | output | 1 | Bus did not reach idle within the pulse limit |

## Verification
Several rules are checked by assertions on every cycle:

- soft reset always covers any line activity and falls only with both lines released;
- done is a lone pulse that comes with busy low;
- an idle start raises busy;
- the poll and pulse counters stay inside their limits.

Other behaviour can only be shown by the bench scenarios. A modelled target holds SDA, or SCL, low for a chosen number of clock pulses, and the pending input stays high for chosen times. This shows the pulse count, early exit at exactly the pulse limit, the stuck flag and its clearing, the poll-bounded delay before soft reset, the exact phase durations, and that a second start pulse has no effect.

// File: rtl/i2c_rcv_pkg.sv
`timescale 1ns/1ps
package i2c_rcv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL,
        ST_RELEASE,
        ST_CHECK,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_START,
        ST_STOP,
        ST_UNRESET
    } rcv_state_e;

    typedef struct packed {
        logic scl_pull;
        logic sda_pull;
        logic ctrl_hold;
        logic active;
    } bus_drive_t;

    function automatic int unsigned clk_count(input int unsigned us, input int unsigned per_us);
        int unsigned n;
        n = us * per_us;
        return (n == 0) ? 1 : n;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Line and reset drive for each phase of the sequence.
    function automatic bus_drive_t drive_for(input rcv_state_e st);
        bus_drive_t d;
        d = '0;
        d.active = (st != ST_IDLE);
        case (st)
            ST_RELEASE, ST_CHECK, ST_CLK_HI, ST_STOP: d.ctrl_hold = 1'b1;
            ST_CLK_LO: begin
                d.ctrl_hold = 1'b1;
                d.scl_pull  = 1'b1;
            end
            ST_START: begin
                d.ctrl_hold = 1'b1;
                d.sda_pull  = 1'b1;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2c_rcv_sync.sv
`timescale 1ns/1ps
module i2c_rcv_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [1:0] stage;
            always_ff @(posedge clk) begin
                if (rst) stage <= 2'b11;      // idle bus reads high
                else     stage <= {stage[0], d_i[b]};
            end
            assign q_o[b] = stage[1];
        end
    endgenerate
endmodule

// File: rtl/i2c_rcv_timer.sv
`timescale 1ns/1ps
module i2c_rcv_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt;

    // A load of N keeps expired_o low for N-1 cycles, so the phase lasts N cycles.
    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load_i)        cnt <= load_val_i - W'(1);
        else if (cnt != '0)     cnt <= cnt - W'(1);
    end

    assign expired_o = (cnt == '0);
endmodule

// File: rtl/i2c_rcv_fsm.sv
`timescale 1ns/1ps
module i2c_rcv_fsm
    import i2c_rcv_pkg::*;
#(
    parameter int unsigned POLL_CLKS   = 50,
    parameter int unsigned PULSE_CLKS  = 10,
    parameter int unsigned HOLD_CLKS   = 100,
    parameter int unsigned SETTLE_CLKS = 4,
    parameter int unsigned POLL_MAX    = 10,
    parameter int unsigned PULSE_MAX   = 10,
    parameter int          TW          = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          pending_i,
    input  logic          lines_high_i,
    input  logic          tmr_expired_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output bus_drive_t    drive_o,
    output logic          done_o,
    output logic          stuck_o
);
    localparam int PW = $clog2(POLL_MAX + 1);
    localparam int QW = $clog2(PULSE_MAX + 1);

    rcv_state_e    st, nxt;
    logic [PW-1:0] poll_cnt;
    logic [QW-1:0] pulse_cnt;
    logic          poll_inc, pulse_inc, set_stuck, clr_run, fin;

    always_comb begin
        nxt        = st;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        poll_inc   = 1'b0;
        pulse_inc  = 1'b0;
        set_stuck  = 1'b0;
        clr_run    = 1'b0;
        fin        = 1'b0;
        case (st)
            ST_IDLE: if (start_i) begin
                nxt = ST_POLL; tmr_load_o = 1'b1; tmr_val_o = TW'(POLL_CLKS); clr_run = 1'b1;
            end
            ST_POLL: if (tmr_expired_i) begin
                if (!pending_i || poll_cnt == PW'(POLL_MAX - 1)) begin
                    nxt = ST_RELEASE; tmr_load_o = 1'b1; tmr_val_o = TW'(SETTLE_CLKS);
                end else begin
                    poll_inc = 1'b1; tmr_load_o = 1'b1; tmr_val_o = TW'(POLL_CLKS);
                end
            end
            ST_RELEASE: if (tmr_expired_i) nxt = ST_CHECK;
            ST_CHECK: begin
                tmr_load_o = 1'b1;
                if (lines_high_i) begin
                    nxt = ST_START; tmr_val_o = TW'(HOLD_CLKS);
                end else if (pulse_cnt == QW'(PULSE_MAX)) begin
                    set_stuck = 1'b1; nxt = ST_START; tmr_val_o = TW'(HOLD_CLKS);
                end else begin
                    nxt = ST_CLK_LO; tmr_val_o = TW'(PULSE_CLKS);
                end
            end
            ST_CLK_LO: if (tmr_expired_i) begin
                nxt = ST_CLK_HI; tmr_load_o = 1'b1; tmr_val_o = TW'(PULSE_CLKS);
            end
            ST_CLK_HI: if (tmr_expired_i) begin
                nxt = ST_CHECK; pulse_inc = 1'b1;
            end
            ST_START: if (tmr_expired_i) begin
                nxt = ST_STOP; tmr_load_o = 1'b1; tmr_val_o = TW'(HOLD_CLKS);
            end
            ST_STOP: if (tmr_expired_i) begin
                nxt = ST_UNRESET; tmr_load_o = 1'b1; tmr_val_o = TW'(HOLD_CLKS);
            end
            ST_UNRESET: if (tmr_expired_i) begin
                nxt = ST_IDLE; fin = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            poll_cnt  <= '0;
            pulse_cnt <= '0;
            stuck_o   <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            st     <= nxt;
            done_o <= fin;
            if (clr_run) begin
                poll_cnt  <= '0;
                pulse_cnt <= '0;
                stuck_o   <= 1'b0;
            end else begin
                if (poll_inc)  poll_cnt  <= poll_cnt + PW'(1);
                if (pulse_inc) pulse_cnt <= pulse_cnt + QW'(1);
                if (set_stuck) stuck_o   <= 1'b1;
            end
        end
    end

    assign drive_o = drive_for(st);

    // R3: polling never exceeds its bound
    a_r3_poll_bound: assert property (@(posedge clk) disable iff (rst)
        poll_cnt < PW'(POLL_MAX));
    // R7: pulse counter never passes the limit
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        pulse_cnt <= QW'(PULSE_MAX));
    // R2: a start from idle raises busy next cycle
    a_r2_busy_rise: assert property (@(posedge clk) disable iff (rst)
        (start_i && !drive_o.active) |=> drive_o.active);
    // R9: done is a lone pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R9: done comes with the sequence over and the controller released
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!drive_o.active && !drive_o.ctrl_hold));
endmodule

// File: rtl/i2c_bus_recovery.sv
`timescale 1ns/1ps
module i2c_bus_recovery
    import i2c_rcv_pkg::*;
#(
    parameter int unsigned CLKS_PER_US = 100,
    parameter int unsigned POLL_US     = 500,
    parameter int unsigned PULSE_US    = 100,
    parameter int unsigned HOLD_US     = 1000,
    parameter int unsigned POLL_MAX    = 10,
    parameter int unsigned PULSE_MAX   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic pending_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic ctrl_srst_o,
    output logic busy_o,
    output logic done_o,
    output logic stuck_o
);
    localparam int unsigned POLL_CLKS   = clk_count(POLL_US, CLKS_PER_US);
    localparam int unsigned PULSE_CLKS  = clk_count(PULSE_US, CLKS_PER_US);
    localparam int unsigned HOLD_CLKS   = clk_count(HOLD_US, CLKS_PER_US);
    localparam int unsigned SETTLE_CLKS = 4;   // covers the two synchronizer stages
    localparam int unsigned MAX_CLKS    = max3(POLL_CLKS, PULSE_CLKS, HOLD_CLKS);
    localparam int          TW          = $clog2(MAX_CLKS + 1);

    logic [1:0]    line_q;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    bus_drive_t    drv;

    i2c_rcv_sync #(.WIDTH(2)) u_sync (
        .clk (clk), .rst (rst), .d_i ({scl_i, sda_i}), .q_o (line_q)
    );

    i2c_rcv_timer #(.W(TW)) u_timer (
        .clk (clk), .rst (rst), .load_i (tmr_load), .load_val_i (tmr_val),
        .expired_o (tmr_expired)
    );

    i2c_rcv_fsm #(
        .POLL_CLKS (POLL_CLKS), .PULSE_CLKS (PULSE_CLKS), .HOLD_CLKS (HOLD_CLKS),
        .SETTLE_CLKS (SETTLE_CLKS), .POLL_MAX (POLL_MAX), .PULSE_MAX (PULSE_MAX),
        .TW (TW)
    ) u_fsm (
        .clk (clk), .rst (rst), .start_i (start_i), .pending_i (pending_i),
        .lines_high_i (&line_q), .tmr_expired_i (tmr_expired),
        .tmr_load_o (tmr_load), .tmr_val_o (tmr_val), .drive_o (drv),
        .done_o (done_o), .stuck_o (stuck_o)
    );

    assign scl_oe_o    = drv.scl_pull;
    assign sda_oe_o    = drv.sda_pull;
    assign ctrl_srst_o = drv.ctrl_hold;
    assign busy_o      = drv.active;

    // R4: any line activity happens under soft reset
    a_r4_srst_covers_lines: assert property (@(posedge clk) disable iff (rst)
        (scl_oe_o || sda_oe_o) |-> ctrl_srst_o);
    // R4: soft reset drops only with both lines released
    a_r4_release_on_unreset: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_srst_o) |-> (!scl_oe_o && !sda_oe_o));
endmodule

// File: tb/test_i2c_bus_recovery.sv
`timescale 1ns/1ps
module test_i2c_bus_recovery;
    localparam int T_POLL = 50, T_PULSE = 10, T_HOLD = 100;

    typedef struct packed {
        int pend;      // cycles pending stays high after start
        int k;         // SCL pulses before the jammed line lets go
        bit jam_scl;   // 1: SCL is jammed, 0: SDA is jammed
        bit restart;   // pulse start again mid-sequence
        int pulses;    // expected SCL pulses
        bit stuck;     // expected stuck flag
        int srst;      // expected start-to-soft-reset delay
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{0,     0,  1'b0, 1'b0, 0,  1'b0, 50},
        '{120,   3,  1'b0, 1'b0, 3,  1'b0, 150},
        '{99999, 1,  1'b0, 1'b0, 1,  1'b0, 500},
        '{0,     99, 1'b0, 1'b0, 10, 1'b1, 50},
        '{0,     10, 1'b0, 1'b1, 10, 1'b0, 50},
        '{0,     99, 1'b1, 1'b0, 10, 1'b1, 50},
        '{0,     4,  1'b0, 1'b0, 4,  1'b0, 50}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, pend = 1'b0;
    logic scl_oe, sda_oe, srst, busy, done, stuck;
    logic jam_scl = 1'b0;
    int   k_need = 0, pulses_seen = 0;
    int   n_chk = 0, n_fail = 0, total_cyc = 0;

    wire held = (pulses_seen < k_need);
    wire scl_ln = !scl_oe && !(jam_scl && held);
    wire sda_ln = !sda_oe && !(!jam_scl && held);

    always #2.5 clk = ~clk;

    i2c_bus_recovery #(
        .CLKS_PER_US (1), .POLL_US (T_POLL), .PULSE_US (T_PULSE), .HOLD_US (T_HOLD),
        .POLL_MAX (10), .PULSE_MAX (10)
    ) i_i2c_bus_recovery (
        .clk (clk), .rst (rst), .start_i (start), .pending_i (pend),
        .scl_i (scl_ln), .sda_i (sda_ln), .scl_oe_o (scl_oe), .sda_oe_o (sda_oe),
        .ctrl_srst_o (srst), .busy_o (busy), .done_o (done), .stuck_o (stuck)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int cyc = 0, npul = 0, lo_len = 0, bad_w = 0, bad_st = 0, bad_rst = 0, n_done = 0;
        int t_srise = -1, t_sda_r = -1, t_sda_f = -1, t_sfall = -1, t_done = -1;
        bit busy1 = 1'b0, busy_at_done = 1'b1, stuck_at_done = 1'b0;
        bit p_scl = 1'b0, p_sda = 1'b0, p_srst = 1'b0;
        pulses_seen = 0; k_need = v.k; jam_scl = v.jam_scl;
        @(negedge clk);
        start = 1'b1; pend = (0 < v.pend);
        while (cyc < 20000 && !(t_done >= 0 && cyc >= t_done + 3)) begin
            @(negedge clk);
            cyc++;
            start = (v.restart && cyc == 199);
            pend  = (cyc < v.pend);
            if (cyc == 1) busy1 = busy;
            if (srst && !p_srst && t_srise < 0) t_srise = cyc;
            if (!srst && p_srst) t_sfall = cyc;
            if ((scl_oe || sda_oe) && !srst) bad_rst++;
            if (scl_oe && !p_scl) begin npul++; pulses_seen++; end
            if (scl_oe) lo_len++;
            if (!scl_oe && p_scl) begin
                if (lo_len != T_PULSE) bad_w++;
                lo_len = 0;
            end
            if (sda_oe && !p_sda) t_sda_r = cyc;
            if (!sda_oe && p_sda) t_sda_f = cyc;
            if (sda_oe && scl_oe) bad_st++;
            if (done) begin
                n_done++;
                if (t_done < 0) begin t_done = cyc; busy_at_done = busy; stuck_at_done = stuck; end
            end
            p_scl = scl_oe; p_sda = sda_oe; p_srst = srst;
        end
        start = 1'b0; pend = 1'b0; k_need = 0;
        chk(t_done >= 0, "watchdog R9 sequence finished", cyc, 0);
        chk(busy1, "R2 busy after start", busy1, 1);
        chk(t_srise >= v.srst + 1 && t_srise <= v.srst + 2, "R3 poll delay", t_srise, v.srst + 1);
        if (v.pulses == 0) chk(npul == 0, "R5 no clocking when idle", npul, 0);
        else               chk(npul == v.pulses, "R6 pulse count", npul, v.pulses);
        chk(stuck_at_done == v.stuck, "R7 stuck flag", stuck_at_done, v.stuck);
        chk(bad_w == 0, "R6 low phase width", bad_w, 0);
        chk(bad_rst == 0, "R4 srst covers lines", bad_rst, 0);
        chk(t_sda_f - t_sda_r == T_HOLD, "R8 start hold", t_sda_f - t_sda_r, T_HOLD);
        chk(bad_st == 0, "R8 scl released in start", bad_st, 0);
        chk(t_sfall - t_sda_f == T_HOLD, "R8 stop hold", t_sfall - t_sda_f, T_HOLD);
        chk(t_done - t_sfall == T_HOLD, "R9 done after unreset", t_done - t_sfall, T_HOLD);
        chk(n_done == 1, v.restart ? "R2 restart ignored" : "R9 single done", n_done, 1);
        chk(!busy_at_done, "R9 busy low at done", busy_at_done, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!scl_oe && !sda_oe && !srst && !busy && !done && !stuck, "R1 reset state",
            {scl_oe, sda_oe, srst, busy, done, stuck}, 0);
        foreach (VECS[i]) run_vec(VECS[i]);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", total_cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule